// File: doc/BRIEF.md
# Shared Bus Arbiter with Exclusive Lock

This block decides which of several agents owns a single shared bus. The agents may be processor cores or devices that move data to and from memory on their own. Each agent raises a request. An agent that needs an indivisible read-modify-write, or any other group of transfers, also raises a lock line before its first transfer and keeps it high until its last transfer has completed. While that lock is held, the owner keeps the grant across any number of back-to-back transfers. Every other agent waits during that time, whatever kind of traffic it carries. This includes memory reads, memory writes and interrupt messages. The lock covers the whole bus, not a single address range.

When no lock is held, a round-robin pointer shares the bus fairly among the pending requesters. A lock that is never released would stall the system for good. A watchdog therefore counts the cycles of continuous lock against a limit set at an input. On expiry it takes the bus back and sets an error flag that stays set until it is cleared explicitly.

Top module: `bus_lock_arbiter`

## Requirements
- R1: After a synchronous reset, `gnt`, `lock_busy`, `txn_active`, `bus_xtype` and `lock_err` are all zero.
- R2: A transfer starts on the edge at which the owner is granted (or re-granted under lock), and `txn_active` rises with it. `txn_active` stays high until the edge that samples `done` high for the owner. A `done` from any other agent has no effect.
- R3: With the bus free, the grant goes to the first requester found at or after the index just past the last granted agent, wrapping around. After reset, agent 0 is examined first. `gnt` is one-hot with bit i meaning agent i.
- R4: The owner's lock bit is captured on the edge that grants it, and `lock_busy` is high from that edge on. While the lock is held and no transfer is active, a high request from the owner starts another transfer without a change of grant.
- R5: While `lock_busy` is high, no other agent is granted. This holds for every transaction-type code and every kind of agent.
- R6: A lock bit raised by an agent that does not own the grant has no effect until that agent is granted.
- R7: `gnt` changes only on an edge where no transfer is active and no lock is held. When the owner lowers its lock with no transfer active, `lock_busy` falls on the next edge, and arbitration resumes on the edge after that.
- R8: Each agent supplies a TYPE_W-bit type code at bits [i*TYPE_W +: TYPE_W] of `xtype`. `bus_xtype` takes the owner's code on the edge a transfer starts and otherwise holds it.
- R9: `lock_busy` is never high for more than `wdog_limit`+1 consecutive cycles. On the edge that ends such a run, the watchdog clears the grant, the active transfer and the lock.
- R10: `lock_err` is set on a watchdog expiry and stays set until an edge with `err_clr` high and no expiry. An expiry on the same edge as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_AGENTS | Per-agent bus request |
| lock | input | N_AGENTS | Per-agent exclusive-sequence request |
| xtype | input | N_AGENTS*TYPE_W | Per-agent transaction-type code |
| done | input | N_AGENTS | Per-agent transfer-complete pulse |
| wdog_limit | input | WDOG_W | Lock watchdog limit in cycles |
| err_clr | input | 1 | Clears the sticky lock error |
| gnt | output | N_AGENTS | One-hot bus grant |
| lock_busy | output | 1 | Bus is held under lock |
| txn_active | output | 1 | A transfer is in progress |
| bus_xtype | output | TYPE_W | Type code of the current transfer |
| lock_err | output | 1 | Sticky watchdog-expiry flag |

## Verification
The assertions assume that an agent pulses `done` only while it owns an active transfer. They also assume that `wdog_limit` does not change while a lock is held. The stimulus follows both assumptions: it drives inputs only on falling edges, and it keeps the watchdog limit constant throughout each test. It does drive a `done` pulse from a non-owner on purpose, during an active locked transfer, to show that such a pulse is ignored. It also drives a lock bit from an agent that does not hold the grant, to show that this bit is ignored too.

// File: rtl/lockarb_pkg.sv
package lockarb_pkg;
  // index that follows cur in a ring of n agents
  function automatic int unsigned ring_step(input int unsigned cur, input int unsigned k,
                                            input int unsigned n);
    return (cur + k) % n;
  endfunction
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N_AGENTS = 4,
  localparam int IW = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic [N_AGENTS-1:0] req,
  input  logic [IW-1:0]       last,
  output logic [N_AGENTS-1:0] pick,
  output logic [IW-1:0]       sel,
  output logic                valid
);
  import lockarb_pkg::*;

  always_comb begin
    pick  = '0;
    sel   = '0;
    valid = 1'b0;
    for (int k = 1; k <= N_AGENTS; k++) begin
      int unsigned idx;
      idx = ring_step(int'(last), k, N_AGENTS);
      if (!valid && req[idx]) begin
        valid     = 1'b1;
        sel       = IW'(idx);
        pick[idx] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lock_wdog.sv
module lock_wdog #(
  parameter int WDOG_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              locked,
  input  logic [WDOG_W-1:0] limit,
  input  logic              clr,
  output logic              expire,
  output logic              err
);
  logic [WDOG_W-1:0] cnt_q;

  assign expire = locked && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      err   <= 1'b0;
    end else begin
      cnt_q <= (locked && !expire) ? cnt_q + 1'b1 : '0;
      if (expire)   err <= 1'b1;
      else if (clr) err <= 1'b0;
    end
  end

  p_err_set_r10: assert property (@(posedge clk) disable iff (rst)
    expire |=> err);
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (err && !clr) |=> err);
  p_cnt_bounded_r9: assert property (@(posedge clk) disable iff (rst)
    locked |-> (cnt_q <= limit));
endmodule

// File: rtl/bus_lock_arbiter.sv
module bus_lock_arbiter #(
  parameter int N_AGENTS = 4,
  parameter int TYPE_W   = 2,
  parameter int WDOG_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_AGENTS-1:0]        req,
  input  logic [N_AGENTS-1:0]        lock,
  input  logic [N_AGENTS*TYPE_W-1:0] xtype,
  input  logic [N_AGENTS-1:0]        done,
  input  logic [WDOG_W-1:0]          wdog_limit,
  input  logic                       err_clr,
  output logic [N_AGENTS-1:0]        gnt,
  output logic                       lock_busy,
  output logic                       txn_active,
  output logic [TYPE_W-1:0]          bus_xtype,
  output logic                       lock_err
);
  localparam int IW = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1;

  logic [N_AGENTS-1:0] gnt_q;
  logic [IW-1:0]       own_q;
  logic                busy_q;
  logic                locked_q;
  logic [TYPE_W-1:0]   xtype_q;

  logic [N_AGENTS-1:0] pick;
  logic [IW-1:0]       sel;
  logic                pick_valid;
  logic                expire;

  rr_pick #(.N_AGENTS(N_AGENTS)) u_pick (
    .req  (req),
    .last (own_q),
    .pick (pick),
    .sel  (sel),
    .valid(pick_valid)
  );

  lock_wdog #(.WDOG_W(WDOG_W)) u_wdog (
    .clk   (clk),
    .rst   (rst),
    .locked(locked_q),
    .limit (wdog_limit),
    .clr   (err_clr),
    .expire(expire),
    .err   (lock_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q    <= '0;
      own_q    <= IW'(N_AGENTS - 1);
      busy_q   <= 1'b0;
      locked_q <= 1'b0;
      xtype_q  <= '0;
    end else if (expire) begin
      gnt_q    <= '0;
      busy_q   <= 1'b0;
      locked_q <= 1'b0;
    end else if (busy_q) begin
      if (done[own_q]) busy_q <= 1'b0;
      locked_q <= locked_q && lock[own_q];
    end else if (locked_q) begin
      locked_q <= lock[own_q];
      if (lock[own_q] && req[own_q]) begin
        busy_q  <= 1'b1;
        xtype_q <= xtype[own_q*TYPE_W +: TYPE_W];
      end
    end else if (pick_valid) begin
      gnt_q    <= pick;
      own_q    <= sel;
      busy_q   <= 1'b1;
      locked_q <= lock[sel];
      xtype_q  <= xtype[sel*TYPE_W +: TYPE_W];
    end else begin
      gnt_q <= '0;
    end
  end

  assign gnt        = gnt_q;
  assign lock_busy  = locked_q;
  assign txn_active = busy_q;
  assign bus_xtype  = xtype_q;

  p_onehot_gnt_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_q));
  p_pick_legal_r3: assert property (@(posedge clk) disable iff (rst)
    pick_valid |-> (((pick & req) == pick) && $onehot(pick)));
  p_active_owned_r2: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> gnt_q[own_q]);
  p_lock_owned_r5: assert property (@(posedge clk) disable iff (rst)
    locked_q |-> (gnt_q == (N_AGENTS'(1) << own_q)));
  p_hold_grant_r7: assert property (@(posedge clk) disable iff (rst)
    ((busy_q || locked_q) && !expire) |=> $stable(gnt_q));
  p_expire_release_r9: assert property (@(posedge clk) disable iff (rst)
    expire |=> (!locked_q && !busy_q && gnt_q == '0));
endmodule

// File: tb/test_bus_lock_arbiter.sv
module test_bus_lock_arbiter;
  localparam int N = 4;
  localparam int TW = 2;
  localparam int WW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req = '0, lock = '0, done = '0;
  logic [N*TW-1:0] xtype = {2'd3, 2'd2, 2'd1, 2'd0};
  logic [WW-1:0] wdog_limit = 16'd100;
  logic err_clr = 1'b0;
  logic [N-1:0] gnt;
  logic lock_busy, txn_active, lock_err;
  logic [TW-1:0] bus_xtype;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  bus_lock_arbiter #(.N_AGENTS(N), .TYPE_W(TW), .WDOG_W(WW)) i_bus_lock_arbiter (
    .clk(clk), .rst(rst), .req(req), .lock(lock), .xtype(xtype), .done(done),
    .wdog_limit(wdog_limit), .err_clr(err_clr), .gnt(gnt), .lock_busy(lock_busy),
    .txn_active(txn_active), .bus_xtype(bus_xtype), .lock_err(lock_err));

  // req, lock, done | expected gnt, lock_busy, txn_active, bus_xtype
  localparam logic [19:0] VEC [0:12] = '{
    {4'b0011, 4'b0000, 4'b0000, 4'b0001, 1'b0, 1'b1, 2'd0},
    {4'b0011, 4'b0000, 4'b0001, 4'b0001, 1'b0, 1'b0, 2'd0},
    {4'b0011, 4'b0000, 4'b0000, 4'b0010, 1'b0, 1'b1, 2'd1},
    {4'b0011, 4'b0000, 4'b0010, 4'b0010, 1'b0, 1'b0, 2'd1},
    {4'b0101, 4'b0100, 4'b0000, 4'b0100, 1'b1, 1'b1, 2'd2},
    {4'b0101, 4'b0101, 4'b0100, 4'b0100, 1'b1, 1'b0, 2'd2},
    {4'b0101, 4'b0100, 4'b0001, 4'b0100, 1'b1, 1'b1, 2'd2},
    {4'b0101, 4'b0100, 4'b0001, 4'b0100, 1'b1, 1'b1, 2'd2},
    {4'b0101, 4'b0100, 4'b0100, 4'b0100, 1'b1, 1'b0, 2'd2},
    {4'b0001, 4'b0000, 4'b0000, 4'b0100, 1'b0, 1'b0, 2'd2},
    {4'b0001, 4'b0000, 4'b0000, 4'b0001, 1'b0, 1'b1, 2'd0},
    {4'b0001, 4'b0000, 4'b0001, 4'b0001, 1'b0, 1'b0, 2'd0},
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 2'd0}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; req = '0; lock = '0; done = '0; err_clr = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog: bench hung, actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    int run;
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 gnt", int'(gnt), 0);
    check("R1 lock_busy", int'(lock_busy), 0);
    check("R1 txn_active", int'(txn_active), 0);
    check("R1 lock_err", int'(lock_err), 0);
    check("R1 bus_xtype", int'(bus_xtype), 0);

    // table: round robin, lock hold, stall of others, ignored lock and done
    for (int v = 0; v < 13; v++) begin
      {req, lock, done} = VEC[v][19:8];
      @(negedge clk);
      check($sformatf("R3 R5 R7 gnt vec%0d", v), int'(gnt), int'(VEC[v][7:4]));
      check($sformatf("R4 R6 lock_busy vec%0d", v), int'(lock_busy), int'(VEC[v][3]));
      check($sformatf("R2 txn_active vec%0d", v), int'(txn_active), int'(VEC[v][2]));
      check($sformatf("R8 bus_xtype vec%0d", v), int'(bus_xtype), int'(VEC[v][1:0]));
    end

    // R9 stuck lock released by the watchdog
    do_reset();
    wdog_limit = 16'd5;
    req = 4'b0010; lock = 4'b0010;
    run = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (lock_busy) run++;
      else if (run > 0) break;
    end
    req = '0; lock = '0;
    check("R9 lock run length", run, 6);
    check("R9 gnt after expiry", int'(gnt), 0);
    check("R9 txn_active after expiry", int'(txn_active), 0);
    check("R10 lock_err set", int'(lock_err), 1);
    repeat (3) @(negedge clk);
    check("R10 lock_err sticky", int'(lock_err), 1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    check("R10 lock_err cleared", int'(lock_err), 0);

    // R1 reset also clears an error
    wdog_limit = 16'd0;
    req = 4'b1000; lock = 4'b1000;
    repeat (3) @(negedge clk);
    req = '0; lock = '0;
    check("R10 expiry at limit 0", int'(lock_err), 1);
    do_reset();
    check("R1 reset clears lock_err", int'(lock_err), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule